// File: doc/BRIEF.md
# Serial SAR Converter Host Sequencer

This block sits on the host side of an external 16-bit successive-approximation converter that has a serial result output. It drives three lines toward the converter: the sample strobe, the conversion clock and the calibration request. It watches the converter's busy line and reads the serial result line. On the host side it takes a one-cycle start command, a calibration command and a continuous-mode level. It returns a sign-extended parallel result with a one-cycle valid pulse, a ready flag and a timeout pulse.

A conversion has three phases. First the strobe is held high for a sampling window. Then the strobe is dropped and the conversion clock stays quiet for a settling delay. Then a burst of exactly 17 conversion clock pulses runs. The result arrives MSB first in twos complement and is taken on the falling clock edges of pulses 2 to 17. After the burst the block waits for busy to fall before it accepts new work.

In continuous mode the next acquisition starts on the rising edge of the final pulse. A calibration command aborts any activity at once. It holds the calibration line high for a short pulse and then supplies the long stream of clocks that calibration needs. All timing is counted in system clocks. Every input is assumed to be synchronous to `clk`.

Top module: `sar_host_ctrl`

## Requirements
- R1: After synchronous reset, ready_o is 1 and adc_sample_o, adc_clk_o, adc_cal_o, valid_o and timeout_o are all 0.
- R2: A start_i seen while ready drives adc_sample_o high on the next edge. The strobe stays high until SAMPLE_CYC cycles with adc_busy_i low have been counted, which is exactly SAMPLE_CYC cycles when busy stays low.
- R3: The first conversion clock rises exactly max(SLOW_CYC, FCD_CYC) cycles after adc_sample_o falls, and adc_clk_o is low while the strobe falls.
- R4: Each conversion issues exactly 17 adc_clk_o pulses, each high for HALF_CYC cycles. adc_clk_o never rises while adc_sample_o was already high in the previous cycle.
- R5: adc_sdata_i is taken on the falling edges of pulses 2 to 17. The pulse 2 bit is result bit 15 (MSB) and the pulse 17 bit is bit 0. valid_o is high for exactly one cycle, starting on the edge where pulse 17 falls. In that cycle result_o[15:0] holds the code and bits OUT_W-1 to 16 all copy bit 15.
- R6: After a burst, ready_o stays low until adc_busy_i is sampled low. When ready_o is high, adc_sample_o and adc_cal_o are low.
- R7: If cont_i is high when pulse 17 rises, adc_sample_o rises on that same edge while adc_clk_o is still high, so conversions chain. Clearing cont_i lets the conversion in flight complete and then return to idle.
- R8: cal_i has priority in every state. On the next edge adc_cal_o goes high, adc_clk_o and adc_sample_o go low, the burst is abandoned and no valid_o follows. adc_cal_o stays high for CALHI_CYC cycles after the last cycle cal_i was high.
- R9: When adc_cal_o falls, the block waits max(SLOW_CYC, FCD_CYC) cycles and then issues exactly CAL_CLKS clock pulses while ignoring adc_sdata_i. It then waits for adc_busy_i low before setting ready_o.
- R10: If adc_busy_i stays high for WDOG_CYC consecutive cycles while the block waits on it, timeout_o pulses for one cycle and the block returns to idle.
- R11: A start_i seen while ready_o is low is dropped and never causes a later acquisition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to begin a conversion |
| cal_i | input | 1 | Calibration request, aborts any activity |
| cont_i | input | 1 | Level: chain conversions back to back |
| result_o | output | OUT_W | Sign-extended conversion result |
| valid_o | output | 1 | One-cycle qualifier for result_o |
| ready_o | output | 1 | Idle and able to accept start_i |
| timeout_o | output | 1 | One-cycle pulse: busy did not fall in time |
| adc_sample_o | output | 1 | Sample strobe to the converter |
| adc_clk_o | output | 1 | Gated conversion clock to the converter |
| adc_cal_o | output | 1 | Calibration request line to the converter |
| adc_busy_i | input | 1 | Converter busy flag |
| adc_sdata_i | input | 1 | Converter serial result, MSB first |

## Verification
The bench aims at these corner cases:
- **Extreme codes.** Full-scale positive, full-scale negative, zero and all-ones codes catch a capture that starts at pulse 1 or ends at pulse 16, which would shift every bit by one. They also catch a sign extension that copies the wrong bit.
- **Continuous chaining.** The strobe must rise while the seventeenth pulse is still high. A design that waits for the burst to end loses that overlap. One that chains without waiting for busy would start counting the sampling window too early.
- **Calibration abort mid-burst.** A wrong design would emit a stray valid pulse, count the wrong number of calibration clocks, or leave the clock running under the calibration line.
- **Stuck-busy converter.** The watchdog must fire; without it the block would hang with ready low.
- **Starts while busy.** A start issued during a conversion must be dropped. A design that latches it would start a second acquisition.

// File: rtl/sar_host_pkg.sv
package sar_host_pkg;

    localparam int CODE_W      = 16;
    localparam int CONV_PULSES = 17;
    localparam int FIRST_CAP   = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACQ,
        ST_HOLD,
        ST_BURST,
        ST_WAITB,
        ST_CALP
    } seq_state_t;

    typedef struct packed {
        logic rise;
        logic fall;
        logic last_rise;
        logic done;
    } burst_evt_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int bits_for(input int v);
        return (v > 1) ? $clog2(v + 1) : 1;
    endfunction

endpackage

// File: rtl/sar_burst_gen.sv
module sar_burst_gen
    import sar_host_pkg::*;
#(
    parameter int HALF_CYC = 4,
    parameter int CNT_W    = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go_i,
    input  logic             abort_i,
    input  logic [CNT_W-1:0] count_i,
    output logic             sclk_o,
    output logic [CNT_W-1:0] idx_o,
    output burst_evt_t       evt_o
);
    localparam int HW = bits_for(HALF_CYC);

    logic             running;
    logic             clk_q;
    logic [HW-1:0]    hcnt;
    logic [CNT_W-1:0] pidx;
    logic [CNT_W-1:0] cnt_q;
    logic             half_end;

    assign half_end = running && (hcnt == HW'(HALF_CYC - 1));
    assign sclk_o   = clk_q;
    assign idx_o    = pidx;

    always_comb begin
        evt_o.fall      = half_end && clk_q;
        evt_o.rise      = half_end && !clk_q && (pidx != cnt_q);
        evt_o.last_rise = half_end && !clk_q && ((pidx + CNT_W'(1)) == cnt_q);
        evt_o.done      = half_end && !clk_q && (pidx == cnt_q);
    end

    always_ff @(posedge clk) begin
        if (rst || abort_i) begin
            running <= 1'b0;
            clk_q   <= 1'b0;
            hcnt    <= '0;
            pidx    <= '0;
            cnt_q   <= '0;
        end else if (go_i) begin
            running <= 1'b1;
            clk_q   <= 1'b1;
            hcnt    <= '0;
            pidx    <= CNT_W'(1);
            cnt_q   <= count_i;
        end else if (running) begin
            if (half_end) begin
                hcnt <= '0;
                if (clk_q) begin
                    clk_q <= 1'b0;
                end else if (pidx == cnt_q) begin
                    running <= 1'b0;
                end else begin
                    clk_q <= 1'b1;
                    pidx  <= pidx + CNT_W'(1);
                end
            end else begin
                hcnt <= hcnt + HW'(1);
            end
        end
    end

endmodule

// File: rtl/sar_shift_cap.sv
module sar_shift_cap
    import sar_host_pkg::*;
#(
    parameter int OUT_W = 32,
    parameter int CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cap_en_i,
    input  logic             fall_i,
    input  logic [CNT_W-1:0] idx_i,
    input  logic             sdata_i,
    output logic [OUT_W-1:0] result_o,
    output logic             valid_o
);
    logic [CODE_W-2:0] sh;
    logic [CODE_W-1:0] word;
    logic              take;
    logic              last;

    assign word = {sh, sdata_i};
    assign take = cap_en_i && fall_i && (idx_i >= CNT_W'(FIRST_CAP));
    assign last = take && (idx_i == CNT_W'(CONV_PULSES));

    always_ff @(posedge clk) begin
        if (rst) begin
            sh       <= '0;
            result_o <= '0;
            valid_o  <= 1'b0;
        end else begin
            valid_o <= last;
            if (take) begin
                sh <= word[CODE_W-2:0];
            end
            if (last) begin
                result_o <= {{(OUT_W - CODE_W){word[CODE_W-1]}}, word};
            end
        end
    end

endmodule

// File: rtl/sar_seq_fsm.sv
module sar_seq_fsm
    import sar_host_pkg::*;
#(
    parameter int SAMPLE_CYC = 200,
    parameter int HOLD_CYC   = 50,
    parameter int CALHI_CYC  = 10,
    parameter int WDOG_CYC   = 4096,
    parameter int CAL_CLKS   = 85532,
    parameter int CNT_W      = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             cal_i,
    input  logic             cont_i,
    input  logic             busy_i,
    input  burst_evt_t       evt_i,
    output logic             sample_o,
    output logic             cal_o,
    output logic             go_o,
    output logic             abort_o,
    output logic [CNT_W-1:0] count_o,
    output logic             cal_mode_o,
    output logic             ready_o,
    output logic             timeout_o
);
    localparam int CW  = bits_for(imax(imax(SAMPLE_CYC, HOLD_CYC), CALHI_CYC));
    localparam int WDW = bits_for(WDOG_CYC);

    seq_state_t     state;
    logic [CW-1:0]  cnt;
    logic [WDW-1:0] wd;
    logic           cal_mode;
    logic           wd_on;
    logic           wd_hit;

    assign wd_on   = ((state == ST_WAITB) || (state == ST_ACQ)) && busy_i;
    assign wd_hit  = wd_on && (wd == WDW'(WDOG_CYC - 1));
    assign go_o    = (state == ST_HOLD) && (cnt == CW'(HOLD_CYC - 1)) && !cal_i;
    assign abort_o = cal_i;
    assign count_o = cal_mode ? CNT_W'(CAL_CLKS) : CNT_W'(CONV_PULSES);
    assign cal_mode_o = cal_mode;
    assign ready_o = (state == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            wd        <= '0;
            cal_mode  <= 1'b0;
            sample_o  <= 1'b0;
            cal_o     <= 1'b0;
            timeout_o <= 1'b0;
        end else begin
            timeout_o <= 1'b0;
            wd        <= wd_on ? wd + WDW'(1) : '0;
            if (cal_i) begin
                state    <= ST_CALP;
                cnt      <= '0;
                wd       <= '0;
                cal_mode <= 1'b1;
                cal_o    <= 1'b1;
                sample_o <= 1'b0;
            end else if (wd_hit) begin
                state     <= ST_IDLE;
                wd        <= '0;
                sample_o  <= 1'b0;
                timeout_o <= 1'b1;
            end else begin
                unique case (state)
                    ST_IDLE: begin
                        if (start_i) begin
                            state    <= ST_ACQ;
                            cnt      <= '0;
                            cal_mode <= 1'b0;
                            sample_o <= 1'b1;
                        end
                    end
                    ST_ACQ: begin
                        if (!busy_i) begin
                            if (cnt == CW'(SAMPLE_CYC - 1)) begin
                                state    <= ST_HOLD;
                                cnt      <= '0;
                                sample_o <= 1'b0;
                            end else begin
                                cnt <= cnt + CW'(1);
                            end
                        end
                    end
                    ST_HOLD: begin
                        if (cnt == CW'(HOLD_CYC - 1)) begin
                            state <= ST_BURST;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                    ST_BURST: begin
                        if (evt_i.last_rise && cont_i && !cal_mode) begin
                            state    <= ST_ACQ;
                            cnt      <= '0;
                            sample_o <= 1'b1;
                        end else if (evt_i.done) begin
                            state <= ST_WAITB;
                        end
                    end
                    ST_WAITB: begin
                        if (!busy_i) begin
                            state    <= ST_IDLE;
                            cal_mode <= 1'b0;
                        end
                    end
                    ST_CALP: begin
                        if (cnt == CW'(CALHI_CYC - 1)) begin
                            state <= ST_HOLD;
                            cnt   <= '0;
                            cal_o <= 1'b0;
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/sar_host_ctrl.sv
module sar_host_ctrl
    import sar_host_pkg::*;
#(
    parameter int OUT_W      = 32,
    parameter int HALF_CYC   = 4,
    parameter int SAMPLE_CYC = 200,
    parameter int SLOW_CYC   = 20,
    parameter int FCD_CYC    = 50,
    parameter int CALHI_CYC  = 10,
    parameter int CAL_CLKS   = 85532,
    parameter int WDOG_CYC   = 4096
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             cal_i,
    input  logic             cont_i,
    output logic [OUT_W-1:0] result_o,
    output logic             valid_o,
    output logic             ready_o,
    output logic             timeout_o,
    output logic             adc_sample_o,
    output logic             adc_clk_o,
    output logic             adc_cal_o,
    input  logic             adc_busy_i,
    input  logic             adc_sdata_i
);
    localparam int HOLD_CYC = imax(SLOW_CYC, FCD_CYC);
    localparam int CNT_W    = bits_for(imax(CAL_CLKS, CONV_PULSES));

    burst_evt_t       evt;
    logic             go;
    logic             abort;
    logic             cal_mode;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] idx;

    sar_seq_fsm #(
        .SAMPLE_CYC (SAMPLE_CYC),
        .HOLD_CYC   (HOLD_CYC),
        .CALHI_CYC  (CALHI_CYC),
        .WDOG_CYC   (WDOG_CYC),
        .CAL_CLKS   (CAL_CLKS),
        .CNT_W      (CNT_W)
    ) seq_i (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .cal_i      (cal_i),
        .cont_i     (cont_i),
        .busy_i     (adc_busy_i),
        .evt_i      (evt),
        .sample_o   (adc_sample_o),
        .cal_o      (adc_cal_o),
        .go_o       (go),
        .abort_o    (abort),
        .count_o    (count),
        .cal_mode_o (cal_mode),
        .ready_o    (ready_o),
        .timeout_o  (timeout_o)
    );

    sar_burst_gen #(
        .HALF_CYC (HALF_CYC),
        .CNT_W    (CNT_W)
    ) burst_i (
        .clk     (clk),
        .rst     (rst),
        .go_i    (go),
        .abort_i (abort),
        .count_i (count),
        .sclk_o  (adc_clk_o),
        .idx_o   (idx),
        .evt_o   (evt)
    );

    sar_shift_cap #(
        .OUT_W (OUT_W),
        .CNT_W (CNT_W)
    ) cap_i (
        .clk      (clk),
        .rst      (rst),
        .cap_en_i (!cal_mode),
        .fall_i   (evt.fall),
        .idx_i    (idx),
        .sdata_i  (adc_sdata_i),
        .result_o (result_o),
        .valid_o  (valid_o)
    );

endmodule

// File: rtl/sar_host_chk.sv
module sar_host_chk #(
    parameter int OUT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic [OUT_W-1:0] result_o,
    input logic             valid_o,
    input logic             ready_o,
    input logic             timeout_o,
    input logic             adc_sample_o,
    input logic             adc_clk_o,
    input logic             adc_cal_o,
    input logic             adc_busy_i
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        $fell(rst) |-> ready_o && !adc_sample_o && !adc_clk_o && !adc_cal_o);

    assert_strobe_falls_clock_low_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(adc_sample_o) |-> !adc_clk_o);

    assert_no_clock_in_sampling_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(adc_clk_o) |-> !$past(adc_sample_o));

    assert_valid_single_R5: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    assert_sign_copy_R5: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (result_o[OUT_W-1:15] == '0) || (result_o[OUT_W-1:15] == '1));

    assert_ready_lines_low_R6: assert property (@(posedge clk) disable iff (rst)
        ready_o |-> !adc_sample_o && !adc_cal_o);

    assert_cal_silences_R8: assert property (@(posedge clk) disable iff (rst)
        adc_cal_o |-> !adc_sample_o && !adc_clk_o && !valid_o);

    assert_timeout_on_busy_R10: assert property (@(posedge clk) disable iff (rst)
        timeout_o |-> $past(adc_busy_i) && ready_o);

    assert_timeout_single_R10: assert property (@(posedge clk) disable iff (rst)
        timeout_o |=> !timeout_o);

endmodule

bind sar_host_ctrl sar_host_chk #(.OUT_W(OUT_W)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .result_o     (result_o),
    .valid_o      (valid_o),
    .ready_o      (ready_o),
    .timeout_o    (timeout_o),
    .adc_sample_o (adc_sample_o),
    .adc_clk_o    (adc_clk_o),
    .adc_cal_o    (adc_cal_o),
    .adc_busy_i   (adc_busy_i)
);

// File: tb/sar_host_ctrl_tb_top.sv
module sar_host_ctrl_tb_top;
    localparam int OUT_W = 32;
    localparam int HALF  = 2;
    localparam int SAMP  = 4;
    localparam int SLOW  = 3;
    localparam int FCD   = 5;
    localparam int CALHI = 3;
    localparam int CALN  = 40;
    localparam int WDOG  = 64;
    localparam int HOLD  = (SLOW > FCD) ? SLOW : FCD;
    localparam int NVEC  = 6;

    // each entry: {code[15:0], expected result[31:0]}
    localparam logic [47:0] VEC [NVEC] = '{
        {16'h7FFF, 32'h0000_7FFF},
        {16'h8000, 32'hFFFF_8000},
        {16'h0000, 32'h0000_0000},
        {16'hFFFF, 32'hFFFF_FFFF},
        {16'h1234, 32'h0000_1234},
        {16'hA5C3, 32'hFFFF_A5C3}
    };
    localparam logic [15:0] CONT_CODE [4] = '{16'h8001, 16'h7FFE, 16'h00FF, 16'hFF00};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0, cal_i = 1'b0, cont_i = 1'b0;
    logic [OUT_W-1:0] result_o;
    logic valid_o, ready_o, timeout_o, adc_sample_o, adc_clk_o, adc_cal_o;
    logic adc_busy_i = 1'b0, adc_sdata_i = 1'b0;

    int n_chk = 0, n_fail = 0;

    always #5 clk = ~clk;

    sar_host_ctrl #(
        .OUT_W(OUT_W), .HALF_CYC(HALF), .SAMPLE_CYC(SAMP), .SLOW_CYC(SLOW),
        .FCD_CYC(FCD), .CALHI_CYC(CALHI), .CAL_CLKS(CALN), .WDOG_CYC(WDOG)
    ) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .cal_i(cal_i), .cont_i(cont_i),
        .result_o(result_o), .valid_o(valid_o), .ready_o(ready_o), .timeout_o(timeout_o),
        .adc_sample_o(adc_sample_o), .adc_clk_o(adc_clk_o), .adc_cal_o(adc_cal_o),
        .adc_busy_i(adc_busy_i), .adc_sdata_i(adc_sdata_i)
    );

    task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // converter model and line monitors, all evaluated at the falling clock edge
    logic p_samp = 0, p_clk = 0, p_cal = 0;
    logic [15:0] mdl_code = 0, cur_code = 0;
    bit hang = 0, mcal = 0, pend = 0;
    int rcnt = 0, dcnt = 0;
    int s_hi = 0, s_hi_last = 0, gap = 0, gap_last = 0;
    bit gap_arm = 0;
    int rises_last = 0, cal_rises_last = 0, cal_hi = 0, cal_hi_last = 0;
    int hi_run = 0, width_bad = 0, srise_cnt = 0, valid_cnt = 0;
    logic clk_at_srise = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (adc_sample_o) s_hi++;
            else if (p_samp) begin s_hi_last = s_hi; s_hi = 0; end
            if (adc_sample_o && !p_samp) begin srise_cnt++; clk_at_srise = adc_clk_o; end
            if (adc_cal_o) cal_hi++;
            else if (p_cal) begin cal_hi_last = cal_hi; cal_hi = 0; end
            if (!adc_sample_o && p_samp) begin gap_arm = 1; gap = 0; end
            if (gap_arm) begin
                if (adc_clk_o) begin gap_last = gap; gap_arm = 0; end
                else gap++;
            end
            if (adc_clk_o) hi_run++;
            else if (p_clk) begin if (hi_run != HALF) width_bad++; hi_run = 0; end
            if (valid_o) valid_cnt++;

            if (adc_cal_o) begin
                adc_busy_i = 1; mcal = 1; pend = 0; rcnt = 0;
            end else begin
                if (!adc_sample_o && p_samp && !adc_busy_i) begin
                    adc_busy_i = 1; mcal = 0; rcnt = 0; cur_code = mdl_code;
                end
                if (adc_clk_o && !p_clk && adc_busy_i && !pend) begin
                    rcnt++;
                    if (mcal) adc_sdata_i = rcnt[0];
                    else if (rcnt >= 2 && rcnt <= 17) adc_sdata_i = cur_code[17 - rcnt];
                end
                if (!adc_clk_o && p_clk && adc_busy_i && !pend && rcnt == (mcal ? CALN : 17)) begin
                    pend = 1; dcnt = 0;
                    if (mcal) cal_rises_last = rcnt; else rises_last = rcnt;
                end
                if (pend) begin
                    if (dcnt >= 3 && !hang) begin adc_busy_i = 0; pend = 0; end
                    else dcnt++;
                end
            end
        end
        p_samp = adc_sample_o; p_clk = adc_clk_o; p_cal = adc_cal_o;
    end

    task automatic wait_valid(input int lim);
        int n = 0;
        while (!valid_o && n < lim) begin @(negedge clk); n++; end
    endtask

    task automatic wait_ready(input int lim);
        int n = 0;
        while (!ready_o && n < lim) begin @(negedge clk); n++; end
    endtask

    task automatic pulse_start();
        start_i = 1; @(negedge clk); start_i = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int s0, v0;
        bit seen;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check_eq("R1 ready", ready_o, 1);
        check_eq("R1 lines", {adc_sample_o, adc_clk_o, adc_cal_o, valid_o, timeout_o}, 0);

        for (int i = 0; i < NVEC; i++) begin
            mdl_code = VEC[i][47:32];
            pulse_start();
            wait_valid(400);
            check_eq("R5 result", result_o, VEC[i][31:0]);
            check_eq("R6 ready low at valid", ready_o, 0);
            wait_ready(400);
            check_eq("R6 busy low at ready", adc_busy_i, 0);
            check_eq("R2 sample width", s_hi_last, SAMP);
            check_eq("R3 first clock delay", gap_last, HOLD);
            check_eq("R4 pulse count", rises_last, 17);
            check_eq("R7 no overlap single shot", clk_at_srise, 0);
        end
        check_eq("R4 high phase width", width_bad, 0);

        // R7 continuous chaining
        s0 = srise_cnt;
        cont_i = 1;
        mdl_code = CONT_CODE[0];
        pulse_start();
        for (int k = 0; k < 4; k++) begin
            wait_valid(400);
            check_eq("R7 chained result", result_o, {{16{CONT_CODE[k][15]}}, CONT_CODE[k]});
            if (k < 3) begin
                check_eq("R7 strobe rises in last high", clk_at_srise, 1);
                mdl_code = CONT_CODE[k + 1];
            end
            if (k == 2) cont_i = 0;
            @(negedge clk);
        end
        wait_ready(400);
        check_eq("R7 acquisitions", srise_cnt - s0, 4);
        check_eq("R7 back to idle", ready_o, 1);

        // R11 start dropped while busy
        s0 = srise_cnt; v0 = valid_cnt;
        mdl_code = 16'h4321;
        pulse_start();
        repeat (12) @(negedge clk);
        check_eq("R11 not ready", ready_o, 0);
        pulse_start();
        wait_ready(400);
        repeat (20) @(negedge clk);
        check_eq("R11 one acquisition", srise_cnt - s0, 1);
        check_eq("R11 one result", valid_cnt - v0, 1);

        // R8 / R9 calibration aborting a burst
        v0 = valid_cnt;
        mdl_code = 16'h0F0F;
        pulse_start();
        repeat (20) @(negedge clk);
        cal_i = 1; @(negedge clk); cal_i = 0;
        check_eq("R8 cal line high", adc_cal_o, 1);
        check_eq("R8 clock and strobe low", {adc_clk_o, adc_sample_o}, 0);
        check_eq("R9 not ready during cal", ready_o, 0);
        wait_ready(3000);
        check_eq("R8 cal pulse width", cal_hi_last, CALHI);
        check_eq("R9 cal clock count", cal_rises_last, CALN);
        check_eq("R8 no result from abort", valid_cnt - v0, 0);
        check_eq("R9 ready after cal", ready_o, 1);
        mdl_code = 16'h5A5A;
        pulse_start();
        wait_valid(400);
        check_eq("R9 conversion after cal", result_o, 32'h0000_5A5A);
        wait_ready(400);

        // R10 watchdog on a stuck busy line
        hang = 1;
        mdl_code = 16'h0001;
        pulse_start();
        seen = 0;
        for (int n = 0; n < 600 && !seen; n++) begin
            @(negedge clk);
            if (timeout_o) seen = 1;
        end
        check_eq("R10 timeout pulse", seen, 1);
        @(negedge clk);
        check_eq("R10 idle after timeout", ready_o, 1);
        check_eq("R10 single pulse", timeout_o, 0);
        hang = 0;
        repeat (10) @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule